// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 16-bit processor address into a 20-bit physical address using 4 KB pages. It holds sixteen 8-bit page registers. On every bus cycle the top four bits of the processor address pick one register. That register's value becomes physical bits 19..12, and the low twelve address bits pass through unchanged. This gives a 1 MB physical space. The translation is combinational, so the page is ready in the same cycle as the address.

Software loads the page registers by writing into the sixteen bytes at the very top of the address space. In that window the low four address bits pick the register, and the window cannot be read back. Every access whose upper address byte is all ones skips translation and is flagged as boot ROM, so the boot code stays reachable whatever the registers hold. For every other access, the low nibble of the translated page sorts the access into one of three regions for the system decoder: monitor ROM, I/O or RAM.

Top module: `pgmap_unit`

## Requirements
- R1: While reset is applied and after it is released, register i holds the value i until software changes it. Reading address i·0x1000 therefore shows page i.
- R2: `page_out` equals the register picked by `bus_addr[15:12]`, in the same cycle and with no clock in between. `phys_addr` is `{page_out, bus_addr[11:0]}`.
- R3: A cycle with `bus_valid`=1, `bus_rd`=0 and `bus_addr[15:4]`=0xFFF loads `bus_wdata` into the register numbered `bus_addr[3:0]` at the rising edge. A translation through that register in the next cycle shows the new value.
- R4: No register changes in any of these cases: a write outside 0xFFF0..0xFFFF (including 0xFF00..0xFFEF), a read inside that window, or a cycle with `bus_valid`=0.
- R5: When `bus_valid`=1 and `bus_addr[15:8]`=0xFF, `boot_sel` is 1 and the other three selects are 0, whatever the registers hold.
- R6: Outside the boot range, when `bus_valid`=1 and the translated page has low nibble 0xF, `mon_sel` is the only select that is 1.
- R7: Outside the boot range, when `bus_valid`=1 and the translated page has low nibble 0xE, `io_sel` is the only select that is 1.
- R8: Outside the boot range, when `bus_valid`=1 and the page has any other low nibble, `ram_sel` is the only select that is 1.
- R9: While `bus_valid`=0, all four selects are 0.
- R10: At most one select is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_valid | input | 1 | Bus cycle carries a valid address |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Write data for the page registers |
| page_out | output | 8 | Translated page number (physical bits 19..12) |
| phys_addr | output | 20 | Full physical address |
| boot_sel | output | 1 | Access falls in the untranslated boot range |
| mon_sel | output | 1 | Translated page is monitor ROM |
| io_sel | output | 1 | Translated page is I/O |
| ram_sel | output | 1 | Translated page is RAM |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, 8-bit pages, sixteen registers and 0xF/0xE as the monitor and I/O codes. With these values every register can be reached both through the write window and through the translation index within a few hundred cycles. The same values let the boot range overlap register 15's page, so the bench can show that a reprogrammed register 15 still does not override the bypass. A behavioural model of the sixteen registers predicts the page and the select on every clock. The model is driven through the reset identity map, writes to every register, back-to-back writes to the same register, and writes that must be ignored.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  typedef enum logic [1:0] {
    RGN_BOOT = 2'd0,
    RGN_MON  = 2'd1,
    RGN_IO   = 2'd2,
    RGN_RAM  = 2'd3
  } region_e;
endpackage

// File: rtl/pgmap_rst_sync.sv
module pgmap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pgmap_regs.sv
module pgmap_regs #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 8,
  localparam int NREG  = 1 << IDX_W
) (
  input  logic                         clk,
  input  logic                         srst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NREG-1:0][DATA_W-1:0]  regs_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic              hit;
    logic [DATA_W-1:0] nxt;

    always_comb begin
      hit = wr_en && (wr_idx == IDX_W'(i));
      nxt = hit ? wr_data : regs_q[i];
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) regs_q[i] <= DATA_W'(i);
      else         regs_q[i] <= nxt;
    end
  end

  assign rd_data = regs_q[rd_idx];
endmodule

// File: rtl/pgmap_classify.sv
module pgmap_classify
  import pgmap_pkg::*;
#(
  parameter int          CODE_W   = 4,
  parameter logic [3:0]  MON_CODE = 4'hF,
  parameter logic [3:0]  IO_CODE  = 4'hE
) (
  input  logic              bypass,
  input  logic [CODE_W-1:0] code,
  output region_e           region
);
  always_comb begin
    if (bypass)                      region = RGN_BOOT;
    else if (code == CODE_W'(MON_CODE)) region = RGN_MON;
    else if (code == CODE_W'(IO_CODE))  region = RGN_IO;
    else                             region = RGN_RAM;
  end
endmodule

// File: rtl/pgmap_unit.sv
module pgmap_unit
  import pgmap_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         DATA_W   = 8,
  parameter int         IDX_W    = 4,
  parameter int         BYPASS_W = 8,
  parameter int         CODE_W   = 4,
  parameter logic [3:0] MON_CODE = 4'hF,
  parameter logic [3:0] IO_CODE  = 4'hE,
  localparam int        NREG     = 1 << IDX_W,
  localparam int        OFFS_W   = ADDR_W - IDX_W,
  localparam int        PHYS_W   = DATA_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] page_out,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              boot_sel,
  output logic              mon_sel,
  output logic              io_sel,
  output logic              ram_sel
);
  logic                         srst_n;
  logic                         in_window;
  logic                         in_bypass;
  logic                         map_wr;
  logic [NREG-1:0][DATA_W-1:0]  page_q;
  region_e                      region;

  pgmap_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    in_window = &bus_addr[ADDR_W-1:IDX_W];
    in_bypass = &bus_addr[ADDR_W-1:ADDR_W-BYPASS_W];
    map_wr    = bus_valid && !bus_rd && in_window;
  end

  pgmap_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_regs (
    .clk     (clk),
    .srst_n  (srst_n),
    .wr_en   (map_wr),
    .wr_idx  (bus_addr[IDX_W-1:0]),
    .wr_data (bus_wdata),
    .rd_idx  (bus_addr[ADDR_W-1:OFFS_W]),
    .rd_data (page_out),
    .regs_q  (page_q)
  );

  assign phys_addr = {page_out, bus_addr[OFFS_W-1:0]};

  pgmap_classify #(.CODE_W(CODE_W), .MON_CODE(MON_CODE), .IO_CODE(IO_CODE)) i_classify (
    .bypass (in_bypass),
    .code   (page_out[CODE_W-1:0]),
    .region (region)
  );

  always_comb begin
    boot_sel = bus_valid && (region == RGN_BOOT);
    mon_sel  = bus_valid && (region == RGN_MON);
    io_sel   = bus_valid && (region == RGN_IO);
    ram_sel  = bus_valid && (region == RGN_RAM);
  end
endmodule

// File: rtl/pgmap_checker.sv
module pgmap_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4,
  parameter int CODE_W = 4,
  localparam int NREG  = 1 << IDX_W
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        srst_n,
  input logic                        bus_valid,
  input logic                        bus_rd,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic [DATA_W-1:0]           page_out,
  input logic                        boot_sel,
  input logic                        mon_sel,
  input logic                        io_sel,
  input logic                        ram_sel,
  input logic [NREG-1:0][DATA_W-1:0] page_q
);
  logic win_wr;
  assign win_wr = bus_valid && !bus_rd && (&bus_addr[ADDR_W-1:IDX_W]);

  // R3: a window write lands in the addressed register
  assert_window_write_R3: assert property (@(posedge clk) disable iff (!srst_n)
    win_wr |=> page_q[$past(bus_addr[IDX_W-1:0])] == $past(bus_wdata));

  // R4: without a window write nothing moves
  assert_no_stray_write_R4: assert property (@(posedge clk) disable iff (!srst_n)
    !win_wr |=> $stable(page_q));

  // R5: boot range wins over any mapping
  assert_boot_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (&bus_addr[ADDR_W-1:ADDR_W-8])) |-> boot_sel);

  // R6: monitor page code selects monitor ROM
  assert_mon_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !(&bus_addr[ADDR_W-1:ADDR_W-8]) && (&page_out[CODE_W-1:0])) |-> mon_sel);

  // R9: idle bus, no selects
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> !(boot_sel || mon_sel || io_sel || ram_sel));

  // R10: selects are exclusive
  assert_sel_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({boot_sel, mon_sel, io_sel, ram_sel}));
endmodule

bind pgmap_unit pgmap_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CODE_W(CODE_W)
) i_pgmap_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .srst_n    (srst_n),
  .bus_valid (bus_valid),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .page_out  (page_out),
  .boot_sel  (boot_sel),
  .mon_sel   (mon_sel),
  .io_sel    (io_sel),
  .ram_sel   (ram_sel),
  .page_q    (page_q)
);

// File: tb/test_pgmap_unit.sv
module test_pgmap_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_rd;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  page_out;
  logic [19:0] phys_addr;
  logic        boot_sel, mon_sel, io_sel, ram_sel;

  int model [16];
  bit model_live;
  int n_cmp, n_bad;
  bit finished;

  pgmap_unit i_pgmap_unit (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .page_out(page_out),
    .phys_addr(phys_addr), .boot_sel(boot_sel), .mon_sel(mon_sel),
    .io_sel(io_sel), .ram_sel(ram_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: addr=%h actual=%0h expected=%0h", req, bus_addr, act, exp);
    end
  endtask

  // one bus cycle: drive, compare against the model, clock, update the model
  task automatic cyc(bit v, bit rd, logic [15:0] a, logic [7:0] d, string req);
    int pg, exp_sel;
    bit byp;
    @(negedge clk);
    bus_valid = v; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #2;
    pg  = model[a[15:12]];
    byp = (a[15:8] == 8'hFF);
    if (!v)                  exp_sel = 4'b0000;
    else if (byp)            exp_sel = 4'b1000;
    else if (pg[3:0] == 4'hF) exp_sel = 4'b0100;
    else if (pg[3:0] == 4'hE) exp_sel = 4'b0010;
    else                     exp_sel = 4'b0001;
    chk({req, " R2 page"}, page_out, pg);
    chk({req, " R2 phys"}, phys_addr, (pg << 12) | a[11:0]);
    chk({req, " R5-R10 sel"}, {boot_sel, mon_sel, io_sel, ram_sel}, exp_sel);
    @(posedge clk);
    if (model_live && v && !rd && a[15:4] == 12'hFFF) model[a[3:0]] = d;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; finished = 0; model_live = 0;
    for (int i = 0; i < 16; i++) model[i] = i;
    rst_n = 1'b0; bus_valid = 0; bus_rd = 1; bus_addr = '0; bus_wdata = '0;
    // R1: identity map visible while in reset
    for (int i = 0; i < 16; i++) cyc(1, 1, 16'(i << 12) | 16'h0123, 8'h00, "R1 reset");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(0, 1, 16'h0000, 8'h00, "R9 idle");
    model_live = 1;
    for (int i = 0; i < 16; i++) cyc(1, 1, 16'(i << 12), 8'h00, "R1 after release");
    // R3: program every register, read back through translation
    for (int i = 0; i < 16; i++) cyc(1, 0, 16'hFFF0 | 16'(i), 8'(8'h30 + i * 7), "R3 write");
    for (int i = 0; i < 16; i++) cyc(1, 1, 16'(i << 12) | 16'h0ABC, 8'h00, "R3 readback");
    // R3: back-to-back, then immediate use
    cyc(1, 0, 16'hFFF2, 8'h5E, "R3 b2b");
    cyc(1, 0, 16'hFFF2, 8'h41, "R3 b2b");
    cyc(1, 1, 16'h2ABC, 8'h00, "R3 next-cycle");
    // R6 R7 R8 regions
    cyc(1, 0, 16'hFFF0, 8'h3F, "R6 setup");
    cyc(1, 1, 16'h0010, 8'h00, "R6 mon");
    cyc(1, 0, 16'hFFF4, 8'hFE, "R7 setup");
    cyc(1, 0, 16'hFFF5, 8'h0D, "R8 setup");
    cyc(1, 1, 16'h4001, 8'h00, "R7 io");
    cyc(1, 0, 16'h5002, 8'h00, "R8 ram");
    cyc(0, 1, 16'h4001, 8'h00, "R9 idle io");
    // R4: ignored writes
    cyc(1, 0, 16'hFF24, 8'hAA, "R4 bypass-nonwindow");
    cyc(0, 0, 16'hFFF3, 8'hBB, "R4 invalid");
    cyc(1, 1, 16'hFFF5, 8'hCC, "R4 window read");
    cyc(1, 0, 16'h1234, 8'hDD, "R4 low write");
    for (int i = 0; i < 16; i++) cyc(1, 1, 16'(i << 12) | 16'h0777, 8'h00, "R4 readback");
    // R5: boot range regardless of register 15
    cyc(1, 0, 16'hFFFF, 8'h2E, "R5 setup");
    cyc(1, 1, 16'hFF80, 8'h00, "R5 boot");
    cyc(1, 1, 16'hF080, 8'h00, "R7 F0xx io");
    cyc(1, 0, 16'hFFFF, 8'h1F, "R5 setup2");
    cyc(1, 1, 16'hFF00, 8'h00, "R5 boot2");
    cyc(1, 1, 16'hFEFF, 8'h00, "R6 below boot");
    report();
  end
endmodule